// File: doc/BRIEF.md
# Byte-Fed CRC-16 Accumulator

This block computes a 16-bit frame check sequence over a byte stream that software pushes in one byte per register write. It sits beside the infrared link controller and lets software check a frame without a bit loop. A write to the data register folds the low byte of the write data into the running checksum. A saturating byte counter records how many bytes have been absorbed since the last clear. A write to the control register with its top bit set clears both. The counter is read back through the control register, and the checksum through a separate result register.

The checksum uses the generator x^16+x^12+x^5+1. It shifts least-significant bit first, starts from all ones and is complemented on read. With these choices the four bytes 0xCC, 0xF5, 0xF1, 0xA7 give 0x51DF, and power-on diagnostics can use that value as a known-answer test. A small state machine tracks the counter's condition:
- EMPTY is entered on reset or on a clear.
- EMPTY goes to ACCUM on the first absorbed byte.
- ACCUM goes to SATURATED when the byte that brings the count to 0xFFF arrives.
- SATURATED holds until the next clear.

Every state returns to EMPTY on a clear. A data write that arrives in the same cycle as a clear is dropped.

Top module: `crc16_byte_engine`

## Requirements
- R1: After rst_n is released, the control read returns 0x0000 and the result read returns 0x0000 (internal state all ones, complemented on read).
- R2: A data write (dat_we=1) feeds only wdata[7:0] into the checksum; wdata[15:8] has no effect on the result.
- R3: Each data write raises the count by one. The control read (rd_sel=2'b00) returns the count in bits 11:0 and zero in bits 15:12.
- R4: A control write (ctl_we=1) with wdata[15]=1 clears the count to 0 and returns the result read to 0x0000.
- R5: A control write with wdata[15]=0 changes neither count nor result.
- R6: After a clear, the bytes 0xCC, 0xF5, 0xF1, 0xA7 leave the count at 4 and the result read at 0x51DF.
- R7: A data write updates the checksum and the count at the clock edge on which it is sampled, so a read in the next cycle shows the new values.
- R8: The count stops at 0xFFF and stays there on further data writes, while the checksum keeps absorbing those bytes.
- R9: When a clearing control write and a data write share a cycle, the clear wins and the byte is discarded.
- R10: rd_sel=2'b01 returns the complemented checksum; rd_sel values 2'b10 and 2'b11 return 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_we | input | 1 | Write strobe for the control register |
| dat_we | input | 1 | Write strobe for the data register |
| wdata | input | 16 | Write data shared by both registers |
| rd_sel | input | 2 | Read select: 00 control/count, 01 result |
| rdata | output | 16 | Combinational read data |

## Verification
A clear and a byte write can land on the same clock edge, and so can a byte write and counter saturation. The bench drives both strobes together on a clean engine and after several bytes have been absorbed. It expects the count at zero and the result at 0x0000, with no trace of the byte. The saturation edge is reached by streaming 4095 bytes and then more. The reference model must show the count frozen while the checksum still moves, and each case is compared on every clock through both read selects.

// File: rtl/crc16_eng_pkg.sv
package crc16_eng_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY     = 2'd0,
        ST_ACCUM     = 2'd1,
        ST_SATURATED = 2'd2
    } eng_state_t;

    localparam logic [1:0] SEL_CTRL   = 2'b00;
    localparam logic [1:0] SEL_RESULT = 2'b01;
endpackage

// File: rtl/crc16_byte_step.sv
module crc16_byte_step #(
    parameter int              CRC_W = 16,
    parameter logic [CRC_W-1:0] POLY = 16'h8408
) (
    input  logic [CRC_W-1:0] crc_in,
    input  logic [7:0]       byte_in,
    output logic [CRC_W-1:0] crc_out
);
    localparam int NBITS = 8;

    logic [CRC_W-1:0] stage [0:NBITS];

    assign stage[0] = crc_in ^ {{(CRC_W-NBITS){1'b0}}, byte_in};

    for (genvar gi = 0; gi < NBITS; gi++) begin : g_bit
        assign stage[gi+1] = stage[gi][0] ? ((stage[gi] >> 1) ^ POLY)
                                          : (stage[gi] >> 1);
    end

    assign crc_out = stage[NBITS];
endmodule

// File: rtl/crc16_sat_counter.sv
module crc16_sat_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= '0;
        else if (inc)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/crc16_read_mux.sv
module crc16_read_mux #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 12,
    parameter int CRC_W  = 16
) (
    input  logic [1:0]        sel,
    input  logic [CNT_W-1:0]  count,
    input  logic [CRC_W-1:0]  result,
    output logic [DATA_W-1:0] rdata
);
    import crc16_eng_pkg::*;

    always_comb begin
        case (sel)
            SEL_CTRL:   rdata = {{(DATA_W-CNT_W){1'b0}}, count};
            SEL_RESULT: rdata = result;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/crc16_byte_engine.sv
module crc16_byte_engine #(
    parameter int               DATA_W  = 16,
    parameter int               CNT_W   = 12,
    parameter int               CRC_W   = 16,
    parameter logic [CRC_W-1:0] POLY    = 16'h8408,
    parameter logic [CRC_W-1:0] INIT    = 16'hFFFF,
    parameter logic [CRC_W-1:0] XOROUT  = 16'hFFFF,
    parameter int               CLR_BIT = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic              dat_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rdata
);
    import crc16_eng_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_MAX - 1'b1;

    eng_state_t       state_q, state_d;
    logic             clr, feed, cnt_inc;
    logic [CRC_W-1:0] crc_q, crc_next;
    logic [CNT_W-1:0] cnt_q;
    logic             unused_wbits;

    assign unused_wbits = ^wdata;
    assign clr  = ctl_we & wdata[CLR_BIT];
    assign feed = dat_we & ~clr;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_EMPTY;
        else
            state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        cnt_inc = 1'b0;
        if (clr) begin
            state_d = ST_EMPTY;
        end else if (feed) begin
            unique case (state_q)
                ST_EMPTY, ST_ACCUM: begin
                    cnt_inc = 1'b1;
                    state_d = (cnt_q == CNT_LAST) ? ST_SATURATED : ST_ACCUM;
                end
                ST_SATURATED: begin
                    cnt_inc = 1'b0;
                    state_d = ST_SATURATED;
                end
                default: state_d = ST_EMPTY;
            endcase
        end
    end

    crc16_byte_step #(.CRC_W(CRC_W), .POLY(POLY)) u_step (
        .crc_in  (crc_q),
        .byte_in (wdata[7:0]),
        .crc_out (crc_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            crc_q <= INIT;
        else if (clr)
            crc_q <= INIT;
        else if (feed)
            crc_q <= crc_next;
    end

    crc16_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .inc   (cnt_inc),
        .count (cnt_q)
    );

    crc16_read_mux #(.DATA_W(DATA_W), .CNT_W(CNT_W), .CRC_W(CRC_W)) u_rmux (
        .sel    (rd_sel),
        .count  (cnt_q),
        .result (crc_q ^ XOROUT),
        .rdata  (rdata)
    );
endmodule

// File: rtl/crc16_engine_chk.sv
module crc16_engine_chk #(
    parameter int               DATA_W  = 16,
    parameter int               CNT_W   = 12,
    parameter int               CRC_W   = 16,
    parameter logic [CRC_W-1:0] INIT    = 16'hFFFF,
    parameter logic [CRC_W-1:0] XOROUT  = 16'hFFFF,
    parameter int               CLR_BIT = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_we,
    input logic              dat_we,
    input logic [DATA_W-1:0] wdata,
    input logic [1:0]        rd_sel,
    input logic [DATA_W-1:0] rdata,
    input logic [CRC_W-1:0]  crc_q,
    input logic [CNT_W-1:0]  cnt_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic do_clr;
    assign do_clr = ctl_we & wdata[CLR_BIT];

    a_r4_clear_count: assert property (@(posedge clk) disable iff (!rst_n)
        do_clr |=> (cnt_q == '0));

    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (do_clr && dat_we) |=> (crc_q == INIT) && (cnt_q == '0));

    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && !do_clr && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

    a_r8_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !do_clr) |=> (cnt_q == CNT_MAX));

    a_r5_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!dat_we && !do_clr) |=> ($stable(crc_q) && $stable(cnt_q)));

    a_r10_spare_sel_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sel[1] |-> (rdata == '0));

    a_r10_result_path: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 2'b01) |-> (rdata == DATA_W'(crc_q ^ XOROUT)));

    a_r3_ctrl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 2'b00) |-> (rdata[DATA_W-1:CNT_W] == '0));
endmodule

bind crc16_byte_engine crc16_engine_chk #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .CRC_W(CRC_W),
    .INIT(INIT), .XOROUT(XOROUT), .CLR_BIT(CLR_BIT)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl_we (ctl_we),
    .dat_we (dat_we),
    .wdata  (wdata),
    .rd_sel (rd_sel),
    .rdata  (rdata),
    .crc_q  (crc_q),
    .cnt_q  (cnt_q)
);

// File: tb/tb_crc16_byte_engine.sv
module tb_crc16_byte_engine;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic        dat_we = 1'b0;
    logic [15:0] wdata = '0;
    logic [1:0]  rd_sel = 2'b00;
    logic [15:0] rdata;

    int n_cmp = 0;
    int n_bad = 0;
    int m_crc = 'hFFFF;
    int m_cnt = 0;
    logic [15:0] saved;

    always #(CLK_PERIOD/2) clk = ~clk;

    crc16_byte_engine dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .dat_we(dat_we),
        .wdata(wdata), .rd_sel(rd_sel), .rdata(rdata)
    );

    function automatic int fold_byte(int c, int b);
        int v = c ^ (b & 'hFF);
        for (int k = 0; k < 8; k++) begin
            if (v % 2 == 1) v = (v / 2) ^ 'h8408;
            else            v = v / 2;
        end
        return v;
    endfunction

    task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check_both(string tag);
        rd_sel = 2'b00; #1;
        check({tag, " ctrl"}, rdata, 16'(m_cnt));
        rd_sel = 2'b01; #1;
        check({tag, " result"}, rdata, 16'(m_crc ^ 'hFFFF));
    endtask

    // One clock: drive at negedge, update model at the edge, compare after it.
    task automatic step(bit c, bit d, logic [15:0] wd, string tag);
        ctl_we = c; dat_we = d; wdata = wd;
        @(posedge clk);
        if (c && wd[15]) begin
            m_crc = 'hFFFF; m_cnt = 0;
        end else if (d) begin
            m_crc = fold_byte(m_crc, int'(wd));
            if (m_cnt < 4095) m_cnt++;
        end
        @(negedge clk);
        ctl_we = 1'b0; dat_we = 1'b0; wdata = '0;
        check_both(tag);
    endtask

    initial begin
        #(CLK_PERIOD * WDOG_CYCLES);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_both("R1 reset");

        // R6 known-answer vector; R7 each step checks the cycle after the write
        step(1, 0, 16'h8000, "R4 clear");
        step(0, 1, 16'h00CC, "R7 byte0");
        step(0, 1, 16'h00F5, "R7 byte1");
        step(0, 1, 16'h00F1, "R7 byte2");
        step(0, 1, 16'h00A7, "R7 byte3");
        rd_sel = 2'b00; #1; check("R6 count", rdata, 16'h0004);
        rd_sel = 2'b01; #1; check("R6 result", rdata, 16'h51DF);

        // R5 control write without the clear bit
        step(1, 0, 16'h7FFF, "R5 no-clear write");
        rd_sel = 2'b01; #1; check("R5 result kept", rdata, 16'h51DF);
        step(0, 0, 16'h0000, "R5 idle");

        // R10 spare selects
        rd_sel = 2'b10; #1; check("R10 sel2", rdata, 16'h0000);
        rd_sel = 2'b11; #1; check("R10 sel3", rdata, 16'h0000);

        // R2 upper byte ignored
        step(1, 0, 16'h8000, "R4 clear");
        step(0, 1, 16'h0012, "R2 plain");
        rd_sel = 2'b01; #1; saved = rdata;
        step(1, 0, 16'hFFFF, "R4 clear all ones");
        step(0, 1, 16'hAB12, "R2 upper set");
        rd_sel = 2'b01; #1; check("R2 same result", rdata, saved);

        // R9 clear and data in one cycle, on a busy engine and on a clean one
        step(0, 1, 16'h0055, "R3 count");
        step(1, 1, 16'h8077, "R9 clear wins busy");
        step(1, 1, 16'h80AA, "R9 clear wins clean");
        rd_sel = 2'b00; #1; check("R9 count zero", rdata, 16'h0000);

        // R3 varied patterns
        for (int i = 0; i < 20; i++)
            step(0, 1, 16'(i * 37 + 5), "R3 pattern");

        // R8 saturation
        step(1, 0, 16'h8000, "R4 clear");
        for (int i = 0; i < 4100; i++)
            step(0, 1, 16'(i ^ 'h5A), "R8 saturate");
        rd_sel = 2'b00; #1; check("R8 count held", rdata, 16'h0FFF);
        rd_sel = 2'b01; #1; saved = rdata;
        step(0, 1, 16'h0033, "R8 crc still moves");
        rd_sel = 2'b01; #1;
        if (rdata === saved) begin
            n_cmp++; n_bad++;
            $display("FAIL R8 crc frozen: got %h expected change from %h", rdata, saved);
        end else n_cmp++;
        step(1, 0, 16'h8000, "R4 clear after saturation");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule